// File: doc/BRIEF.md
# Supply and Watchdog Reset Controller

This block produces the active-low system reset for a processor subsystem. Two conditions drive it. The first is a digital supply-good flag that an external comparator raises once the supply is above its trip level. It covers both the initial power ramp and later brownouts. The second is a watchdog timer. Firmware restarts it by pulling the shared chip-select/watchdog pin from high to low, so each ordinary serial transaction also counts as a kick.

Reset is released only after the supply flag has stayed good for a programmable number of prescaler ticks. A watchdog timeout produces a reset of that same length. A two-bit select picks one of three watchdog periods or turns the watchdog off. While reset is active, the block raises an inhibit flag for the serial interface. When reset begins in the middle of a transaction, it also gives a one-cycle abort strobe.

All timing counts a prescaled `tick` enable rather than raw clocks. The asynchronous inputs are re-timed by two-flop synchronisers before use.

Top module: `rstgen_supervisor`

## Requirements
- R1: From `rst_n` and for as long as `supply_ok` is low, `rst_out_n` is 0.
- R2: When the synchronised `supply_ok` falls, `rst_out_n` is 0 no later than three clock edges after the input changes.
- R3: `rst_out_n` rises only after `supply_ok` has stayed high for `DLY_TICKS` ticks. If the supply drops during that count, the count restarts from zero.
- R4: Only cycles with `tick` high advance any count. With `tick` held low, reset is never released.
- R5: A high-to-low transition of `csn_wdi` restarts the watchdog count. Transitions spaced closer than the selected timeout keep `rst_out_n` high.
- R6: With the watchdog enabled, `csn_wdi` held high or held low for the selected timeout (in ticks) asserts reset. That reset lasts `DLY_TICKS` ticks, and the watchdog then counts again from zero.
- R7: `wd_sel` encoding: 2'b00 selects `TO_LONG`, 2'b01 selects `TO_MID`, 2'b10 selects `TO_SHORT`, and 2'b11 disables the watchdog.
- R8: `comm_inhibit` is 1 exactly when reset is active.
- R9: `xfer_abort` pulses for one cycle when reset becomes active while the synchronised `csn_wdi` is low. It stays 0 when reset begins with `csn_wdi` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous logic reset, active low |
| tick | input | 1 | Prescaled timing enable |
| supply_ok | input | 1 | Supply-above-trip flag from comparator (async) |
| csn_wdi | input | 1 | Shared chip select / watchdog kick, active low (async) |
| wd_sel | input | 2 | Watchdog period select (R7) |
| rst_out_n | output | 1 | System reset, active low |
| comm_inhibit | output | 1 | Serial interface blocked while high |
| xfer_abort | output | 1 | One-cycle strobe: transaction cut by reset |

## Verification
The hardest case to reach from the ports is the watchdog running close to its limit without expiring. That needs kick intervals just under the timeout, and it needs period changes that occur only while the counter is cleared. The bench reaches it with random kick periods drawn per select setting, parking the select at the disabled code between rounds. A second hard case is a supply dropout partway through the release delay. The bench times a dropout to land in the middle of the count and then confirms the full delay is measured again from the second rise.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Timeout in ticks for a select code; 0 means watchdog disabled.
  function automatic int unsigned wd_limit(input logic [1:0] sel,
                                           input int unsigned t_long,
                                           input int unsigned t_mid,
                                           input int unsigned t_short);
    case (wd_sel_e'(sel))
      WD_LONG:  return t_long;
      WD_MID:   return t_mid;
      WD_SHORT: return t_short;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rg_hold.sv
module rg_hold #(
  parameter int unsigned DLY_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sup_good,
  input  logic wd_trip,
  output logic hold
);
  localparam int unsigned CW = $clog2(DLY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (!sup_good || wd_trip) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold && tick) begin
      if (cnt == LAST) begin
        hold <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_dropout_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_good |=> (hold && cnt == '0));

  p_release_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(tick) && $past(sup_good)));
endmodule

// File: rtl/rg_wdog.sv
module rg_wdog #(
  parameter int unsigned TO_LONG  = 1400,
  parameter int unsigned TO_MID   = 600,
  parameter int unsigned TO_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       trip
);
  localparam int unsigned TMAX = rg_pkg::max3(TO_LONG, TO_MID, TO_SHORT);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  int unsigned   limit;
  logic          en;
  logic          at_end;

  always_comb begin
    limit  = rg_pkg::wd_limit(sel, TO_LONG, TO_MID, TO_SHORT);
    en     = (limit != 0);
    // ">=" also covers a shorter period chosen while the count is high
    at_end = (32'(cnt) + 32'd1 >= limit);
  end

  assign trip = en && !hold && !kick && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold || !en || kick) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  p_kick_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && limit > 1) |=> !trip);

  p_off_never_trips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !trip);
endmodule

// File: rtl/rstgen_supervisor.sv
module rstgen_supervisor #(
  parameter int unsigned DLY_TICKS = 200,
  parameter int unsigned TO_LONG   = 1400,
  parameter int unsigned TO_MID    = 600,
  parameter int unsigned TO_SHORT  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       csn_wdi,
  input  logic [1:0] wd_sel,
  output logic       rst_out_n,
  output logic       comm_inhibit,
  output logic       xfer_abort
);
  // bit 0: supply flag (idle low), bit 1: chip select (idle high)
  logic [1:0] sync_q;
  logic       sup_s;
  logic       cs_s;
  logic       cs_q;
  logic       kick;
  logic       wd_trip;
  logic       hold;
  logic       hold_q;

  rg_sync #(.W(2), .INIT(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({csn_wdi, supply_ok}),
    .q     (sync_q)
  );

  assign sup_s = sync_q[0];
  assign cs_s  = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      hold_q <= 1'b1;
    end else begin
      cs_q   <= cs_s;
      hold_q <= hold;
    end
  end

  assign kick = cs_q & ~cs_s;

  rg_wdog #(.TO_LONG(TO_LONG), .TO_MID(TO_MID), .TO_SHORT(TO_SHORT)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .hold  (hold),
    .kick  (kick),
    .sel   (wd_sel),
    .trip  (wd_trip)
  );

  rg_hold #(.DLY_TICKS(DLY_TICKS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sup_good (sup_s),
    .wd_trip  (wd_trip),
    .hold     (hold)
  );

  assign rst_out_n    = ~hold;
  assign comm_inhibit = hold;
  assign xfer_abort   = hold & ~hold_q & ~cs_s;

  p_supply_low_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> !rst_out_n);

  p_trip_forces_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trip |=> (!rst_out_n && comm_inhibit));

  p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> !xfer_abort);

  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick));

  always_comb begin
    if (rst_n) begin
      p_inhibit_matches_r8: assert (comm_inhibit == !rst_out_n);
    end
  end
endmodule

// File: tb/rstgen_supervisor_tb.sv
module rstgen_supervisor_tb;
  localparam int DLY = 12;
  localparam int TL  = 40;
  localparam int TM  = 20;
  localparam int TS  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       supply_ok = 1'b0;
  logic       csn_wdi = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic       rst_out_n;
  logic       comm_inhibit;
  logic       xfer_abort;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstgen_supervisor #(.DLY_TICKS(DLY), .TO_LONG(TL), .TO_MID(TM), .TO_SHORT(TS)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .supply_ok    (supply_ok),
    .csn_wdi      (csn_wdi),
    .wd_sel       (wd_sel),
    .rst_out_n    (rst_out_n),
    .comm_inhibit (comm_inhibit),
    .xfer_abort   (xfer_abort)
  );

  function automatic int exp_timeout(input logic [1:0] s);
    if (s == 2'b11) return 0;
    if (s == 2'b10) return TS;
    if (s == 2'b01) return TM;
    return TL;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rst(input logic lvl, input int maxc, output int took);
    took = 0;
    while (rst_out_n !== lvl && took < maxc) begin
      @(negedge clk);
      took++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      finish_run();
    end
  end

  initial begin
    int took;
    int lows;
    int pulses;
    void'($urandom(32'd7321));

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 / R8: reset state
    check(rst_out_n == 1'b0, "R1 reset after rst_n", rst_out_n, 0);
    check(comm_inhibit == 1'b1, "R8 inhibit at start", comm_inhibit, 1);
    cyc(20);
    check(rst_out_n == 1'b0, "R1 supply low keeps reset", rst_out_n, 0);

    // R4: no ticks, no release
    tick = 1'b0;
    supply_ok = 1'b1;
    cyc(40);
    check(rst_out_n == 1'b0, "R4 no tick no release", rst_out_n, 0);
    tick = 1'b1;
    cyc(DLY - 1);
    check(rst_out_n == 1'b0, "R3 not released early", rst_out_n, 0);
    wait_rst(1'b1, 6, took);
    check(rst_out_n == 1'b1, "R3 released after delay", rst_out_n, 1);

    // R7: disabled watchdog never fires
    lows = 0;
    for (int i = 0; i < 3 * TL; i++) begin
      @(negedge clk);
      if (!rst_out_n) lows++;
    end
    check(lows == 0, "R7 disabled watchdog", lows, 0);

    // R6 / R7: steady high with short select
    wd_sel = 2'b10;
    wait_rst(1'b0, exp_timeout(2'b10) + 10, took);
    check(took >= exp_timeout(2'b10) - 2 && took <= exp_timeout(2'b10) + 3,
          "R6 steady high timeout", took, exp_timeout(2'b10));
    wait_rst(1'b1, DLY + 8, took);
    check(took >= DLY - 2 && took <= DLY + 2, "R6 watchdog reset length", took, DLY);
    cyc(TS - 2);
    check(rst_out_n == 1'b1, "R6 counter restarts from zero", rst_out_n, 1);
    wait_rst(1'b0, 6, took);
    check(rst_out_n == 1'b0, "R6 second timeout", rst_out_n, 0);
    wd_sel = 2'b11;
    wait_rst(1'b1, DLY + 8, took);

    // R6 / R7: steady low with mid select
    csn_wdi = 1'b0;
    wd_sel = 2'b01;
    wait_rst(1'b0, TM + 12, took);
    check(took >= TM && took <= TM + 6, "R6 steady low timeout", took, TM + 3);
    wd_sel = 2'b11;
    wait_rst(1'b1, DLY + 8, took);
    csn_wdi = 1'b1;
    cyc(4);

    // R5: random kick periods below the timeout
    for (int r = 0; r < 6; r++) begin
      logic [1:0] s;
      int lim;
      s = 2'($urandom_range(0, 2));
      lim = exp_timeout(s);
      wd_sel = s;
      lows = 0;
      for (int k = 0; k < 12; k++) begin
        int p;
        p = $urandom_range(2, lim - 3);
        csn_wdi = 1'b0;
        @(negedge clk);
        if (!rst_out_n) lows++;
        csn_wdi = 1'b1;
        for (int j = 1; j < p; j++) begin
          @(negedge clk);
          if (!rst_out_n) lows++;
        end
      end
      check(lows == 0, "R5 kicks keep reset released", lows, 0);
      wd_sel = 2'b11;
      cyc(2);
    end

    // R2 / R9: supply drop with chip select high, no abort
    pulses = 0;
    supply_ok = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (xfer_abort) pulses++;
    end
    check(rst_out_n == 1'b0, "R2 drop asserts within 3 edges", rst_out_n, 0);
    check(comm_inhibit == 1'b1, "R8 inhibit during brownout", comm_inhibit, 1);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (xfer_abort) pulses++;
    end
    check(pulses == 0, "R9 no abort when idle", pulses, 0);

    // R3: dropout in the middle of the delay restarts it
    supply_ok = 1'b1;
    cyc(DLY / 2 + 2);
    supply_ok = 1'b0;
    cyc(3);
    supply_ok = 1'b1;
    cyc(DLY - 1);
    check(rst_out_n == 1'b0, "R3 dropout restarts delay", rst_out_n, 0);
    wait_rst(1'b1, 6, took);
    check(rst_out_n == 1'b1, "R3 release after restart", rst_out_n, 1);
    check(comm_inhibit == 1'b0, "R8 inhibit clear when released", comm_inhibit, 0);

    // R9: supply drop during a transaction
    csn_wdi = 1'b0;
    cyc(5);
    pulses = 0;
    supply_ok = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (xfer_abort) pulses++;
    end
    check(pulses == 1, "R9 abort strobe on cut transaction", pulses, 1);
    supply_ok = 1'b1;
    csn_wdi = 1'b1;
    wait_rst(1'b1, DLY + 10, took);
    check(rst_out_n == 1'b1, "R3 final release", rst_out_n, 1);

    done = 1'b1;
    finish_run();
  end
endmodule